// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle datapath. It holds eight general registers, each `DATA_W` bits wide. Every clock cycle a 16-bit control word is applied. The word picks two source registers and one destination register. It also chooses the second operand, which is either a register or an external constant. It selects the operation and the writeback source, which is either the operation result or an external data word. Finally, it says whether the destination register is loaded at the next rising edge.

The first operand bus is brought out as an address output. The second operand bus is brought out as a data output. A surrounding sequencer or memory can therefore use a cycle with the write bit clear as a store or output cycle, and a cycle with the external writeback source as a load. The operation result and four status flags (overflow, carry, negative, zero) are exported combinationally. They describe the operation selected in the current cycle.

Top module: `cwdp_datapath`

## Requirements
- R1: Control word fields, bit 15 first: destination address [15:13], A address [12:10], B address [9:7], B-operand select [6], function select [5:2], writeback select [1], write enable [0]. Register addresses 0..7 select R0..R7.
- R2: With bit 6 = 0 the B operand is the register at the B address. With bit 6 = 1 it is `const_in`.
- R3: In every cycle `addr_out` equals the A operand (the register at the A address) and `data_out` equals the B operand.
- R4: With bit 1 = 0 the function result is written back. With bit 1 = 1 `data_in` is written back.
- R5: The destination register is loaded at the rising edge only when bit 0 = 1. With bit 0 = 0 no register changes, whatever the other fields hold.
- R6: Reads are combinational. A register written in a cycle shows its old value during that cycle and its new value from the next cycle on.
- R7: A synchronous active-high `rst` clears all eight registers to zero.
- R8: Arithmetic codes, with F equal to A plus Y plus carry-in: 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1, 0111 A (carry out 1).
- R9: Logic codes: 1000 A AND B, 1001 A OR B, 1010 A XOR B, 1011 NOT A.
- R10: Shift codes act on B with zero fill: 1100 B, 1101 B shifted right one place, 1110 B shifted left one place, 1111 B.
- R11: Flags are packed here as {V,C,N,Z}. N is the result MSB and Z is set when the result is zero. For arithmetic codes C is the adder carry out and V is signed overflow. For all other codes C and V are 0.
- R12: `result_out` and the flags follow the current control word and operands in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register file |
| ctrl_word | input | 16 | Control word for the current cycle |
| const_in | input | DATA_W | External constant for the B operand |
| data_in | input | DATA_W | External writeback data |
| addr_out | output | DATA_W | A operand bus |
| data_out | output | DATA_W | B operand bus |
| result_out | output | DATA_W | Function unit result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
Since both operand buses reach the ports combinationally, a corrupted register shows up as soon as a control word selects it as A or B, in the very same cycle. A lost or misdirected write shows up one cycle later, when the destination is read back. The bench keeps its own register model and compares both buses on every vector. A final sweep over all eight addresses reveals a write that landed on the wrong entry or was suppressed when it should not have been. Errors in the function decode or in the flags appear on `result_out` and the flag pins in the cycle the code is applied.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

  localparam int CW_W      = 16;
  localparam int REG_AW    = 3;
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int FSEL_W    = 4;

  // Field order follows the bit positions of the control word (dst at the top).
  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic              b_const;
    logic [FSEL_W-1:0] fsel;
    logic              d_ext;
    logic              wr;
  } ctrl_t;

  typedef enum logic [FSEL_W-1:0] {
    FN_PASS_A  = 4'b0000,
    FN_INC_A   = 4'b0001,
    FN_ADD     = 4'b0010,
    FN_ADD_C   = 4'b0011,
    FN_ADD_NB  = 4'b0100,
    FN_SUB     = 4'b0101,
    FN_DEC_A   = 4'b0110,
    FN_PASS_AC = 4'b0111,
    FN_AND     = 4'b1000,
    FN_OR      = 4'b1001,
    FN_XOR     = 4'b1010,
    FN_NOT_A   = 4'b1011,
    FN_PASS_B  = 4'b1100,
    FN_SHR_B   = 4'b1101,
    FN_SHL_B   = 4'b1110,
    FN_PASS_B2 = 4'b1111
  } fsel_e;

endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_a_addr,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_a_data,
  output logic [WIDTH-1:0] rd_b_data
);

  logic [DEPTH-1:0][WIDTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0));

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

  // R5
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mem));

endmodule

// File: rtl/cwdp_func_unit.sv
module cwdp_func_unit
  import cwdp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [FSEL_W-1:0] fsel,
  output logic [WIDTH-1:0]  res,
  output logic              v,
  output logic              c,
  output logic              n,
  output logic              z
);

  localparam int MSB = WIDTH - 1;

  // Arithmetic path: F = A + Y + cin, Y chosen by fsel[2:1], cin = fsel[0]
  logic [WIDTH-1:0] y_sel;
  logic [WIDTH:0]   sum_ext;

  always_comb begin
    unique case (fsel[2:1])
      2'b00:   y_sel = '0;
      2'b01:   y_sel = opb;
      2'b10:   y_sel = ~opb;
      default: y_sel = '1;
    endcase
  end

  assign sum_ext = {1'b0, opa} + {1'b0, y_sel} + {{WIDTH{1'b0}}, fsel[0]};

  // Logic path: one slice per bit
  logic [WIDTH-1:0] logic_res;
  for (genvar i = 0; i < WIDTH; i++) begin : g_logic_slice
    assign logic_res[i] = (fsel[1:0] == 2'b00) ? (opa[i] & opb[i]) :
                          (fsel[1:0] == 2'b01) ? (opa[i] | opb[i]) :
                          (fsel[1:0] == 2'b10) ? (opa[i] ^ opb[i]) :
                                                 ~opa[i];
  end

  // Shift path on B, zero fill
  logic [WIDTH-1:0] shift_res;
  always_comb begin
    unique case (fsel[1:0])
      2'b01:   shift_res = {1'b0, opb[MSB:1]};
      2'b10:   shift_res = {opb[MSB-1:0], 1'b0};
      default: shift_res = opb;
    endcase
  end

  logic is_arith;
  assign is_arith = ~fsel[3];

  always_comb begin
    unique case (fsel[3:2])
      2'b10:   res = logic_res;
      2'b11:   res = shift_res;
      default: res = sum_ext[WIDTH-1:0];
    endcase
  end

  assign c = is_arith & sum_ext[WIDTH];
  assign v = is_arith & (opa[MSB] == y_sel[MSB]) & (sum_ext[MSB] != opa[MSB]);
  assign n = res[MSB];
  assign z = (res == '0);

endmodule

// File: rtl/cwdp_datapath.sv
module cwdp_datapath
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] const_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] result_out,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_z
);

  ctrl_t cw;
  assign cw = ctrl_t'(ctrl_word);

  logic [DATA_W-1:0] reg_a, reg_b, bus_a, bus_b, bus_d, fu_res;

  cwdp_regfile #(
    .WIDTH (DATA_W),
    .DEPTH (REG_COUNT)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cw.wr),
    .wr_addr   (cw.dst),
    .wr_data   (bus_d),
    .rd_a_addr (cw.src_a),
    .rd_b_addr (cw.src_b),
    .rd_a_data (reg_a),
    .rd_b_data (reg_b)
  );

  assign bus_a = reg_a;
  assign bus_b = cw.b_const ? const_in : reg_b;

  cwdp_func_unit #(
    .WIDTH (DATA_W)
  ) u_fu (
    .opa  (bus_a),
    .opb  (bus_b),
    .fsel (cw.fsel),
    .res  (fu_res),
    .v    (flag_v),
    .c    (flag_c),
    .n    (flag_n),
    .z    (flag_z)
  );

  assign bus_d      = cw.d_ext ? data_in : fu_res;
  assign addr_out   = bus_a;
  assign data_out   = bus_b;
  assign result_out = fu_res;

  // R2
  const_select_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[6] |-> (data_out == const_in));

  // R8
  add_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word[5:2] == 4'b0010) |->
      ({flag_c, result_out} == ({1'b0, addr_out} + {1'b0, data_out})));

  // R11
  nonarith_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[5] |-> (!flag_c && !flag_v));

endmodule

// File: tb/cwdp_datapath_tb_top.sv
module cwdp_datapath_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 19;

  // {dst,a,b,mb,fs,md,rw} | const | din | exp result | exp {V,C,N,Z}
  localparam logic [43:0] VEC [NV] = '{
    {3'd1,3'd0,3'd0,1'b0,4'b0000,1'b1,1'b1, 8'h00, 8'h25, 8'h00, 4'b0001},
    {3'd2,3'd0,3'd0,1'b0,4'b0000,1'b1,1'b1, 8'h00, 8'h13, 8'h00, 4'b0001},
    {3'd3,3'd0,3'd0,1'b1,4'b1100,1'b0,1'b1, 8'h80, 8'hAA, 8'h80, 4'b0010},
    {3'd0,3'd1,3'd2,1'b0,4'b0010,1'b0,1'b1, 8'h00, 8'h00, 8'h38, 4'b0000},
    {3'd4,3'd1,3'd2,1'b0,4'b0101,1'b0,1'b1, 8'h00, 8'h00, 8'h12, 4'b0100},
    {3'd5,3'd2,3'd1,1'b0,4'b0101,1'b0,1'b1, 8'h00, 8'h00, 8'hEE, 4'b0010},
    {3'd6,3'd3,3'd3,1'b0,4'b0010,1'b0,1'b1, 8'h00, 8'h00, 8'h00, 4'b1101},
    {3'd7,3'd3,3'd0,1'b0,4'b0110,1'b0,1'b1, 8'h00, 8'h00, 8'h7F, 4'b1100},
    {3'd7,3'd1,3'd2,1'b0,4'b1000,1'b0,1'b1, 8'h00, 8'h00, 8'h01, 4'b0000},
    {3'd6,3'd1,3'd2,1'b0,4'b1001,1'b0,1'b1, 8'h00, 8'h00, 8'h37, 4'b0000},
    {3'd5,3'd1,3'd2,1'b0,4'b1010,1'b0,1'b1, 8'h00, 8'h00, 8'h36, 4'b0000},
    {3'd4,3'd1,3'd0,1'b0,4'b1011,1'b0,1'b1, 8'h00, 8'h00, 8'hDA, 4'b0010},
    {3'd3,3'd0,3'd1,1'b0,4'b1101,1'b0,1'b1, 8'h00, 8'h00, 8'h12, 4'b0000},
    {3'd2,3'd0,3'd1,1'b0,4'b1110,1'b0,1'b1, 8'h00, 8'h00, 8'h4A, 4'b0000},
    {3'd0,3'd0,3'd5,1'b0,4'b0001,1'b0,1'b0, 8'h00, 8'h00, 8'h39, 4'b0000},
    {3'd1,3'd1,3'd0,1'b0,4'b0011,1'b0,1'b1, 8'h00, 8'h00, 8'h5E, 4'b0000},
    {3'd2,3'd2,3'd7,1'b0,4'b0111,1'b1,1'b0, 8'h00, 8'h77, 8'h4A, 4'b0100},
    {3'd3,3'd0,3'd0,1'b0,4'b0100,1'b0,1'b0, 8'h00, 8'h00, 8'hFF, 4'b0010},
    {3'd4,3'd6,3'd6,1'b1,4'b1111,1'b0,1'b0, 8'h00, 8'h00, 8'h00, 4'b0001}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   ctrl_word = '0;
  logic [W-1:0]  const_in = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  addr_out, data_out, result_out;
  logic          flag_v, flag_c, flag_n, flag_z;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [W-1:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cwdp_datapath #(.DATA_W(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl_word  (ctrl_word),
    .const_in   (const_in),
    .data_in    (data_in),
    .addr_out   (addr_out),
    .data_out   (data_out),
    .result_out (result_out),
    .flag_v     (flag_v),
    .flag_c     (flag_c),
    .flag_n     (flag_n),
    .flag_z     (flag_z)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cw(input int d, input int a, input int b,
                                        input bit mb, input logic [3:0] fs,
                                        input bit md, input bit rw);
    return {d[2:0], a[2:0], b[2:0], mb, fs, md, rw};
  endfunction

  // Apply a word on the falling edge, settle, return; caller samples.
  task automatic apply(input logic [15:0] cw, input logic [W-1:0] k, input logic [W-1:0] d);
    @(negedge clk);
    ctrl_word = cw;
    const_in  = k;
    data_in   = d;
    #(CLK_PERIOD/4);
  endtask

  task automatic sweep(input string req);
    for (int r = 0; r < 8; r++) begin
      apply(mk_cw(0, r, 7 - r, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
      check(req, {8'h00, addr_out}, {8'h00, model[r]});
      check(req, {8'h00, data_out}, {8'h00, model[7 - r]});
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R7: reset state seen through both buses
    sweep("R7 reset clear");

    // Vector table: R1 R2 R3 R8 R9 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      logic [15:0] cw;
      logic [W-1:0] k, d, exp_res, exp_b;
      logic [3:0] exp_fl;
      cw = VEC[i][43:28]; k = VEC[i][27:20]; d = VEC[i][19:12];
      exp_res = VEC[i][11:4]; exp_fl = VEC[i][3:0];
      apply(cw, k, d);
      exp_b = cw[6] ? k : model[cw[9:7]];
      check("R1/R3 addr_out", {8'h00, addr_out}, {8'h00, model[cw[12:10]]});
      check("R2/R3 data_out", {8'h00, data_out}, {8'h00, exp_b});
      check("R8/R9/R10/R12 result", {8'h00, result_out}, {8'h00, exp_res});
      check("R11 flags", {12'h000, flag_v, flag_c, flag_n, flag_z}, {12'h000, exp_fl});
      @(posedge clk);
      if (cw[0]) model[cw[15:13]] = cw[1] ? d : exp_res;
    end

    // R4 R5: every register against the model, covers suppressed writes
    sweep("R4/R5 contents");

    // R6: written value not visible in the write cycle, visible in the next
    apply(mk_cw(0, 0, 0, 1'b0, 4'b0000, 1'b1, 1'b1), '0, 8'h5A);
    check("R6 old value in write cycle", {8'h00, addr_out}, {8'h00, model[0]});
    @(posedge clk);
    model[0] = 8'h5A;
    apply(mk_cw(1, 0, 0, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
    check("R6 new value next cycle", {8'h00, addr_out}, 16'h005A);

    // R5: external data with write clear has no effect on R3
    apply(mk_cw(3, 3, 3, 1'b0, 4'b0000, 1'b1, 1'b0), '0, 8'hC3);
    @(posedge clk);
    apply(mk_cw(0, 3, 3, 1'b0, 4'b0000, 1'b0, 1'b0), '0, '0);
    check("R5 no load with write clear", {8'h00, addr_out}, {8'h00, model[3]});

    // R10: shift-left drops the MSB, shift-right fills zero at the top
    apply(mk_cw(0, 0, 0, 1'b1, 4'b1110, 1'b0, 1'b0), 8'h81, '0);
    check("R10 shl zero fill", {8'h00, result_out}, 16'h0002);
    apply(mk_cw(0, 0, 0, 1'b1, 4'b1101, 1'b0, 1'b0), 8'h81, '0);
    check("R10 shr zero fill", {8'h00, result_out}, 16'h0040);

    // R7: reset mid-run clears all registers
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 8; r++) model[r] = '0;
    sweep("R7 reset mid-run");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule